// File: doc/BRIEF.md
# Debug Bus Access Arbiter

This block lets a debug command unit borrow the processor's local bus for a single memory access while the core keeps running. When the debug side issues a memory command, the arbiter stalls the core's instruction fetch and waits until the core's bus cycle in progress has drained. It then runs exactly one debug bus cycle, which ends on the slave acknowledge, and hands the bus back to the core. The requester sees a one-cycle done pulse. For reads, the returned data is held on the read-data output from that pulse onward.

Commands that touch the core's own registers cannot run while the core executes. Such a command, issued while the core is not halted, is refused at once: the block pulses done together with an error flag and raises neither the stall nor a bus cycle. A register command issued while the core is halted is accepted. It completes with done and no error, and it uses no bus cycle, because the register path lies outside this block. Only one command is handled at a time. A request that arrives while a command is in progress, or in the cycle done is pulsed, is ignored.

Top module: `dbg_bus_arbiter`

## Requirements
- R1: During and directly after reset, core_fetch_stall, dbg_grant, bus_valid, dbg_done and dbg_err are all 0.
- R2: A memory request (dbg_req=1, dbg_is_reg=0) sampled while idle raises core_fetch_stall on the next cycle. The stall stays high through the done cycle and is 0 the cycle after done.
- R3: The debug bus cycle (bus_valid=1, dbg_grant=1) starts two cycles after the stall rises if core_bus_busy is low, and never starts on a cycle after one in which core_bus_busy was sampled high during the drain wait.
- R4: While bus_valid is 1, bus_addr, bus_wdata and bus_write hold the values captured with the request, and later changes on the dbg_* inputs have no effect on them.
- R5: On a cycle with bus_valid=1 and bus_ack=1, bus_rdata is latched. It appears on dbg_rdata the next cycle and is held until the next acknowledged bus cycle.
- R6: dbg_done is 1 for exactly one cycle, the cycle after the acknowledge. In that cycle dbg_err=0 and bus_valid=0.
- R7: A register request (dbg_is_reg=1) sampled while idle and core_halted=0 gives dbg_done=1 and dbg_err=1 on the next cycle, with no stall and no bus cycle.
- R8: A register request sampled while idle and core_halted=1 gives dbg_done=1 with dbg_err=0 on the next cycle, with no stall and no bus cycle.
- R9: A request sampled while a command is in progress, or in a done cycle, is ignored. It starts no second operation and causes no second done pulse.
- R10: dbg_err is never 1 without dbg_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_req | input | 1 | Debug command request |
| dbg_is_reg | input | 1 | 1 = core register command, 0 = memory command |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | ADDR_W | Memory address |
| dbg_wdata | input | DATA_W | Write data |
| dbg_done | output | 1 | One-cycle completion pulse |
| dbg_err | output | 1 | Refusal flag, valid with dbg_done |
| dbg_grant | output | 1 | Debug side owns the local bus |
| dbg_rdata | output | DATA_W | Latched read data |
| core_halted | input | 1 | Core is halted |
| core_bus_busy | input | 1 | Core bus cycle in flight |
| core_fetch_stall | output | 1 | Stall the core's instruction fetch |
| bus_valid | output | 1 | Debug bus cycle strobe |
| bus_write | output | 1 | Debug cycle direction |
| bus_addr | output | ADDR_W | Debug cycle address |
| bus_wdata | output | DATA_W | Debug cycle write data |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | DATA_W | Slave read data |

## Verification
A wrong sequencer state shows at the ports within one cycle. A missing or late stall, a bus strobe raised while the core bus is still busy, or a done pulse that comes without an acknowledge each shows up on the next clock edge. A broken capture or read-data latch appears as a wrong address or data on the bus strobe cycle, or as a wrong dbg_rdata in the done cycle. A reject path that wrongly stalls or errors shows up on the cycle right after the register request.

// File: rtl/dbgarb_pkg.sv
package dbgarb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STALL  = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_CYCLE  = 3'd3,
        ST_RETURN = 3'd4
    } arb_state_t;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_DATA_W = 32;

    function automatic logic holds_stall(input arb_state_t s);
        return (s != ST_IDLE);
    endfunction

    function automatic logic owns_bus(input arb_state_t s);
        return (s == ST_CYCLE);
    endfunction

endpackage

// File: rtl/dbgarb_capture.sv
module dbgarb_capture
    import dbgarb_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              cap_write,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_write <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
        end else if (take) begin
            cap_write <= in_write;
            cap_addr  <= in_addr;
            cap_wdata <= in_wdata;
        end
    end

endmodule

// File: rtl/dbgarb_seq.sv
module dbgarb_seq
    import dbgarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_start,
    input  logic       core_busy,
    input  logic       ack,
    output arb_state_t state
);

    arb_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (mem_start) nxt = ST_STALL;
            ST_STALL:  nxt = ST_DRAIN;
            ST_DRAIN:  if (!core_busy) nxt = ST_CYCLE;
            ST_CYCLE:  if (ack) nxt = ST_RETURN;
            ST_RETURN: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_DRAIN_GATE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && core_busy) |=> (state == ST_DRAIN)); // R3

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CYCLE && ack) |=> (state == ST_RETURN)); // R6

endmodule

// File: rtl/dbgarb_reject.sv
module dbgarb_reject (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic halted,
    output logic pulse,
    output logic err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            err   <= 1'b0;
        end else begin
            pulse <= fire;
            err   <= fire & ~halted;
        end
    end

    AST_ERR_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |-> pulse); // R10

endmodule

// File: rtl/dbg_bus_arbiter.sv
module dbg_bus_arbiter
    import dbgarb_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_req,
    input  logic              dbg_is_reg,
    input  logic              dbg_write,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              dbg_done,
    output logic              dbg_err,
    output logic              dbg_grant,
    output logic [DATA_W-1:0] dbg_rdata,
    input  logic              core_halted,
    input  logic              core_bus_busy,
    output logic              core_fetch_stall,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    arb_state_t state;
    logic       rej_pulse;
    logic       rej_err;
    logic       idle_ok;
    logic       mem_start;
    logic       reg_start;
    logic       ack_hit;

    assign idle_ok   = (state == ST_IDLE) && !rej_pulse;
    assign mem_start = idle_ok && dbg_req && !dbg_is_reg;
    assign reg_start = idle_ok && dbg_req && dbg_is_reg;

    dbgarb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_start (mem_start),
        .core_busy (core_bus_busy),
        .ack       (bus_ack),
        .state     (state)
    );

    dbgarb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .take      (mem_start),
        .in_write  (dbg_write),
        .in_addr   (dbg_addr),
        .in_wdata  (dbg_wdata),
        .cap_write (bus_write),
        .cap_addr  (bus_addr),
        .cap_wdata (bus_wdata)
    );

    dbgarb_reject u_rej (
        .clk    (clk),
        .rst    (rst),
        .fire   (reg_start),
        .halted (core_halted),
        .pulse  (rej_pulse),
        .err    (rej_err)
    );

    assign core_fetch_stall = holds_stall(state);
    assign bus_valid        = owns_bus(state);
    assign dbg_grant        = owns_bus(state);
    assign ack_hit          = bus_valid && bus_ack;
    assign dbg_done         = (state == ST_RETURN) || rej_pulse;
    assign dbg_err          = rej_err;

    always_ff @(posedge clk) begin
        if (rst)          dbg_rdata <= '0;
        else if (ack_hit) dbg_rdata <= bus_rdata;
    end

    AST_STRB_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> (core_fetch_stall && !$past(core_bus_busy))); // R3

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && $past(bus_valid)) |->
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write))); // R4

    AST_RDATA_LATCH: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> (dbg_rdata == $past(bus_rdata))); // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> (dbg_done && !dbg_err && !bus_valid)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dbg_done |=> !dbg_done); // R9

    AST_STALL_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(core_fetch_stall) |-> $past(dbg_done)); // R2

    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        dbg_err |-> (dbg_done && !core_fetch_stall && !bus_valid)); // R7

endmodule

// File: tb/dbg_bus_arbiter_test.sv
module dbg_bus_arbiter_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst;
    logic dbg_req, dbg_is_reg, dbg_write;
    logic [AW-1:0] dbg_addr;
    logic [DW-1:0] dbg_wdata;
    logic dbg_done, dbg_err, dbg_grant;
    logic [DW-1:0] dbg_rdata;
    logic core_halted, core_bus_busy, core_fetch_stall;
    logic bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic bus_ack;
    logic [DW-1:0] bus_rdata;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    dbg_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .dbg_req(dbg_req), .dbg_is_reg(dbg_is_reg),
        .dbg_write(dbg_write), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_done(dbg_done), .dbg_err(dbg_err), .dbg_grant(dbg_grant),
        .dbg_rdata(dbg_rdata), .core_halted(core_halted),
        .core_bus_busy(core_bus_busy), .core_fetch_stall(core_fetch_stall),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mem_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int drain, input int ackdly, input logic [DW-1:0] rd);
        logic [DW-1:0] old_rd;
        old_rd = dbg_rdata;
        dbg_req = 1; dbg_is_reg = 0; dbg_write = wr; dbg_addr = a; dbg_wdata = wd;
        core_bus_busy = (drain > 0);
        tick();
        // R9: garbage request while busy
        dbg_addr = ~a; dbg_wdata = ~wd; dbg_write = ~wr;
        chk("R2 stall rises", core_fetch_stall, 1);
        chk("R3 no strobe in stall", bus_valid, 0);
        tick();
        chk("R3 no strobe first drain", bus_valid, 0);
        for (int i = 0; i < drain; i++) begin
            tick();
            chk("R3 held while core busy", bus_valid, 0);
            chk("R2 stall in drain", core_fetch_stall, 1);
        end
        core_bus_busy = 0;
        tick();
        chk("R3 strobe", bus_valid, 1);
        chk("R3 grant", dbg_grant, 1);
        chk("R4 addr", bus_addr, a);
        chk("R4 wdata", bus_wdata, wd);
        chk("R4 write", bus_write, wr);
        for (int i = 0; i < ackdly; i++) begin
            tick();
            chk("R4 addr held", bus_addr, a);
            chk("R6 no early done", dbg_done, 0);
        end
        dbg_req = 0;
        bus_ack = 1; bus_rdata = rd;
        tick();
        bus_ack = 0; bus_rdata = '0;
        chk("R6 done", dbg_done, 1);
        chk("R6 no err", dbg_err, 0);
        chk("R6 strobe off", bus_valid, 0);
        chk("R2 stall in done", core_fetch_stall, 1);
        chk("R5 rdata", dbg_rdata, rd);
        dbg_req = 1; dbg_addr = 32'h0BAD_0000;
        tick();
        dbg_req = 0;
        chk("R6 done single", dbg_done, 0);
        chk("R2 stall drops", core_fetch_stall, 0);
        tick();
        chk("R9 ignored in done", core_fetch_stall, 0);
        chk("R5 rdata held", dbg_rdata, rd);
        if (old_rd == rd) chk("R5 sanity", 1, 1);
    endtask

    task automatic reg_op(input logic halted);
        core_halted = halted;
        dbg_req = 1; dbg_is_reg = 1;
        tick();
        dbg_req = 0; dbg_is_reg = 0;
        chk(halted ? "R8 done" : "R7 done", dbg_done, 1);
        chk(halted ? "R8 err" : "R7 err", dbg_err, !halted);
        chk(halted ? "R8 no stall" : "R7 no stall", core_fetch_stall, 0);
        chk(halted ? "R8 no bus" : "R7 no bus", bus_valid, 0);
        tick();
        chk("R10 err clears", dbg_err, 0);
        chk("R9 done single", dbg_done, 0);
        core_halted = 0;
    endtask

    task automatic reg_held();
        // request held two cycles: second sample falls in done cycle
        core_halted = 0;
        dbg_req = 1; dbg_is_reg = 1;
        tick();
        chk("R7 done held req", dbg_done, 1);
        tick();
        dbg_req = 0; dbg_is_reg = 0;
        chk("R9 no second done", dbg_done, 0);
        chk("R10 no lone err", dbg_err, 0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; dbg_req = 0; dbg_is_reg = 0; dbg_write = 0;
        dbg_addr = '0; dbg_wdata = '0; core_halted = 0; core_bus_busy = 0;
        bus_ack = 0; bus_rdata = '0;
        tick(); tick();
        chk("R1 stall in reset", core_fetch_stall, 0);
        chk("R1 valid in reset", bus_valid, 0);
        rst = 0;
        tick();
        chk("R1 stall", core_fetch_stall, 0);
        chk("R1 grant", dbg_grant, 0);
        chk("R1 valid", bus_valid, 0);
        chk("R1 done", dbg_done, 0);
        chk("R1 err", dbg_err, 0);
        mem_op(0, 32'h1000_0040, 32'h0, 0, 0, 32'hCAFE_1234);
        mem_op(1, 32'h2000_0008, 32'h5A5A_A5A5, 3, 2, 32'h1111_2222);
        mem_op(0, 32'hFFFF_FFFC, 32'h0, 1, 4, 32'h8765_4321);
        reg_op(0);
        chk("R7 rdata untouched", dbg_rdata, 32'h8765_4321);
        reg_op(1);
        reg_held();
        mem_op(1, 32'h0000_0000, 32'hFFFF_FFFF, 5, 0, 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule